// File: doc/BRIEF.md
# Carry-Select Adder/Subtractor with Signed Overflow

This block is an 8-bit two's-complement adder/subtractor with no clock and no state. It takes two operands and a mode bit. It returns the result, the raw carry out of the top bit and a signed overflow flag, all within the same cycle as its inputs.

Subtraction adds the bitwise complement of the second operand and forces a carry of one into the least significant bit. The sum is formed from three 4-bit carry-lookahead stages:

- One stage covers the low nibble.
- Two stages compute the high nibble side by side, one assuming an incoming carry of zero and one assuming an incoming carry of one.
- The real carry out of the low nibble then picks one of the two high copies.

Because the high copies are ready early, the carry does not have to pass through the high nibble bit by bit. The longest path is one nibble of lookahead followed by a 2:1 selection.

Top module: `adsub_csel`

## Requirements
- R1: With mode `sub_i` = 0, `res_o` equals (`a_i` + `b_i`) mod 256 and `cout_o` equals bit 8 of the unsigned sum `a_i` + `b_i`.
- R2: With mode `sub_i` = 1, `res_o` equals (`a_i` - `b_i`) mod 256, and `cout_o` is 1 exactly when `a_i` >= `b_i` as unsigned numbers, meaning no borrow occurred.
- R3: In add mode, `ovf_o` is 1 exactly when bit 7 of `a_i` equals bit 7 of `b_i` and bit 7 of `res_o` differs from them.
- R4: In subtract mode, `ovf_o` is 1 exactly when bit 7 of `a_i` differs from bit 7 of `b_i` and bit 7 of `res_o` differs from bit 7 of `a_i`.
- R5: A carry out of bits 3:0 reaches bits 7:4. For example, 0x0F + 0x01 gives 0x10 with `cout_o` = 0, and 0xFF + 0x01 gives 0x00 with `cout_o` = 1.
- R6: All outputs are combinational functions of the present inputs and have settled within the cycle in which the inputs are applied, so there is zero cycles of latency.
- R7: The two high-nibble copies always differ by exactly one modulo 16 (the carry-in-one copy equals the carry-in-zero copy plus one). The result's high nibble matches the copy chosen by the low-nibble carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand (minuend in subtract mode) |
| b_i | input | 8 | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| res_o | output | 8 | Result, modulo 256 |
| cout_o | output | 1 | Raw carry out of bit 7; in subtract mode 1 means no borrow |
| ovf_o | output | 1 | Signed two's-complement overflow |

## Verification
Every result is due in the same cycle as its stimulus because nothing in the path is registered. The bench therefore drives the operands and the mode just after a rising edge and compares all three outputs at the next falling edge. Its reference is computed from integer arithmetic on the requirements. The sweep covers every operand pair in both modes, preceded by directed cases around the nibble carry and the sign boundaries, so each comparison falls half a cycle after the inputs changed.

// File: rtl/adsub_pkg.sv
// Package: adsub_pkg
// Purpose : shared widths and the per-nibble result record for the
//           carry-select adder/subtractor.
// Assumes : the data path is exactly two nibbles wide.
package adsub_pkg;
    parameter int NIB_W  = 4;
    parameter int DATA_W = 2 * NIB_W;

    // Outputs of one lookahead nibble stage.
    typedef struct packed {
        logic [NIB_W-1:0] sum;
        logic             cout;  // carry out of the top bit of the nibble
        logic             ctop;  // carry into the top bit of the nibble
    } nib_res_t;
endpackage

// File: rtl/adsub_operand_prep.sv
// Module : adsub_operand_prep
// Purpose: turns the mode bit into the conditioned second operand and the
//          carry into the least significant bit.
// Assumes: mode 1 means subtract (two's complement via invert plus one).
module adsub_operand_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  logic         sub,
    output logic [W-1:0] b_out,
    output logic         c0
);
    // Purpose: conditional inversion of each operand bit.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_inv
            assign b_out[gi] = b_in[gi] ^ sub;
        end
    endgenerate

    // Purpose: the plus-one of the two's complement enters as carry-in.
    assign c0 = sub;
endmodule

// File: rtl/adsub_cla_nibble.sv
// Module : adsub_cla_nibble
// Purpose: one carry-lookahead adder stage. Every internal carry is formed
//          as a flat sum of products of generate/propagate terms and the
//          stage carry-in, without a ripple chain.
// Assumes: W is small (a nibble), since the product terms grow with W^2.
module adsub_cla_nibble
    import adsub_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output nib_res_t     res
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   carry;

    // Purpose: per-bit generate and propagate.
    assign gen  = x & y;
    assign prop = x ^ y;

    // Purpose: expanded lookahead, carry[i] = OR over j of g[j]&p[j+1..i-1],
    //          plus cin & p[0..i-1].
    always_comb begin
        carry = '0;
        for (int i = 0; i <= W; i++) begin
            logic acc;
            acc = cin;
            for (int k = 0; k < i; k++) acc = acc & prop[k];
            for (int j = 0; j < i; j++) begin
                logic term;
                term = gen[j];
                for (int k = j + 1; k < i; k++) term = term & prop[k];
                acc = acc | term;
            end
            carry[i] = acc;
        end
    end

    // Purpose: sum bits and stage carries.
    assign res.sum  = prop ^ carry[W-1:0];
    assign res.cout = carry[W];
    assign res.ctop = carry[W-1];
endmodule

// File: rtl/adsub_sel_mux.sv
// Module : adsub_sel_mux
// Purpose: picks one of the two speculative high-nibble results using the
//          real carry from the low nibble.
// Assumes: copy0 was computed with carry-in 0, copy1 with carry-in 1.
module adsub_sel_mux
    import adsub_pkg::*;
(
    input  nib_res_t copy0,
    input  nib_res_t copy1,
    input  logic     sel,
    output nib_res_t pick
);
    // Purpose: 2:1 selection of the whole stage record.
    assign pick = sel ? copy1 : copy0;
endmodule

// File: rtl/adsub_csel.sv
// Module : adsub_csel
// Purpose: 8-bit two's-complement adder/subtractor with signed overflow,
//          built as a carry-select of three lookahead nibble stages.
// Assumes: purely combinational; no clock or reset is needed, so the house
//          reset convention does not apply here.
module adsub_csel
    import adsub_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              ovf_o
);
    logic [DATA_W-1:0] b_eff;
    logic              c_lsb;
    nib_res_t          lo_r;
    nib_res_t          hi_r [2];
    nib_res_t          hi_sel;

    // Purpose: operand conditioning for add or subtract.
    adsub_operand_prep #(.W(DATA_W)) u_prep (
        .b_in (b_i),
        .sub  (sub_i),
        .b_out(b_eff),
        .c0   (c_lsb)
    );

    // Purpose: low nibble, fed with the true carry-in.
    adsub_cla_nibble #(.W(NIB_W)) u_lo (
        .x  (a_i[NIB_W-1:0]),
        .y  (b_eff[NIB_W-1:0]),
        .cin(c_lsb),
        .res(lo_r)
    );

    // Purpose: two speculative high-nibble stages, one per carry-in value.
    genvar gc;
    generate
        for (gc = 0; gc < 2; gc++) begin : g_hi
            adsub_cla_nibble #(.W(NIB_W)) u_hi (
                .x  (a_i[DATA_W-1:NIB_W]),
                .y  (b_eff[DATA_W-1:NIB_W]),
                .cin(gc[0]),
                .res(hi_r[gc])
            );
        end
    endgenerate

    // Purpose: carry-select of the high nibble.
    adsub_sel_mux u_sel (
        .copy0(hi_r[0]),
        .copy1(hi_r[1]),
        .sel  (lo_r.cout),
        .pick (hi_sel)
    );

    // Purpose: assemble the outputs; overflow compares carries at bit 7.
    assign res_o  = {hi_sel.sum, lo_r.sum};
    assign cout_o = hi_sel.cout;
    assign ovf_o  = hi_sel.ctop ^ hi_sel.cout;
endmodule

// File: rtl/adsub_csel_chk.sv
// Module : adsub_csel_chk
// Purpose: assertion checker bound into adsub_csel. The block has no clock,
//          so the properties are immediate assertions on settled values.
// Assumes: inputs are two-state when evaluated.
module adsub_csel_chk
    import adsub_pkg::*;
(
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              sub_i,
    input logic [DATA_W-1:0] res_o,
    input logic              cout_o,
    input logic              ovf_o,
    input logic [NIB_W-1:0]  hi0_sum,
    input logic [NIB_W-1:0]  hi1_sum,
    input logic              lo_cout
);
    logic [DATA_W:0]  ref_add;
    logic [DATA_W-1:0] ref_sub;
    logic [NIB_W-1:0] hi0_inc;

    // Purpose: behavioural references for the checks below.
    assign ref_add = {1'b0, a_i} + {1'b0, b_i};
    assign ref_sub = a_i - b_i;
    assign hi0_inc = hi0_sum + 1'b1;

    // Purpose: immediate checks of the arithmetic rules.
    always_comb begin
        if (!sub_i) begin
            p_add_result_r1: assert ({cout_o, res_o} == ref_add)
                else $error("R1 add result mismatch");
            p_add_ovf_r3: assert (ovf_o == ((a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                                            (res_o[DATA_W-1] != a_i[DATA_W-1])))
                else $error("R3 add overflow mismatch");
        end else begin
            p_sub_result_r2: assert (res_o == ref_sub && cout_o == (a_i >= b_i))
                else $error("R2 subtract result mismatch");
            p_sub_ovf_r4: assert (ovf_o == ((a_i[DATA_W-1] != b_i[DATA_W-1]) &&
                                            (res_o[DATA_W-1] != a_i[DATA_W-1])))
                else $error("R4 subtract overflow mismatch");
        end
        p_copies_r7: assert (hi1_sum == hi0_inc)
            else $error("R7 speculative copies not one apart");
        p_pick_r7: assert (res_o[DATA_W-1:NIB_W] == (lo_cout ? hi1_sum : hi0_sum))
            else $error("R7 wrong copy selected");
    end
endmodule

bind adsub_csel adsub_csel_chk u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .res_o  (res_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o),
    .hi0_sum(hi_r[0].sum),
    .hi1_sum(hi_r[1].sum),
    .lo_cout(lo_r.cout)
);

// File: tb/test_adsub_csel.sv
// Bench: test_adsub_csel
// Drives inputs after each rising edge and compares at the falling edge
// against an integer reference; sweeps all operand pairs in both modes.
module test_adsub_csel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a, b;
    logic       sub;
    logic [7:0] res;
    logic       cout, ovf;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    adsub_csel i_adsub_csel (
        .a_i(a), .b_i(b), .sub_i(sub),
        .res_o(res), .cout_o(cout), .ovf_o(ovf)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s a=%02h b=%02h sub=%0d actual=%0h expected=%0h",
                     tag, a, b, sub, act, exp);
        end
    endtask

    // Apply one vector, then check all outputs half a cycle later (R6).
    task automatic apply(input int av, input int bv, input bit sv, input string tag);
        int ia, ib, ir, ec, eo, sa, sb, sr;
        @(posedge clk);
        a = av[7:0]; b = bv[7:0]; sub = sv;
        @(negedge clk);
        ia = av & 255; ib = bv & 255;
        sa = (ia > 127) ? ia - 256 : ia;
        sb = (ib > 127) ? ib - 256 : ib;
        if (!sv) begin
            ir = (ia + ib) & 255; ec = (ia + ib) > 255;     // R1
            sr = sa + sb;
        end else begin
            ir = (ia - ib) & 255; ec = (ia >= ib);          // R2
            sr = sa - sb;
        end
        eo = (sr > 127 || sr < -128);                       // R3 / R4
        cmp({tag, " res"}, int'(res), ir);
        cmp({tag, " cout"}, int'(cout), ec);
        cmp({tag, " ovf"}, int'(ovf), eo);
    endtask

    initial begin : watchdog
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        a = 8'h00; b = 8'h00; sub = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero inputs give zero outputs (R6).
        cmp("R6 idle res", int'(res), 0);
        cmp("R6 idle flags", int'({cout, ovf}), 0);
        // Nibble carry propagation (R5).
        apply(8'h0F, 8'h01, 1'b0, "R5 nib");
        apply(8'hFF, 8'h01, 1'b0, "R5 wrap");
        apply(8'h10, 8'h01, 1'b1, "R5 borrow");
        // Sign boundaries (R3, R4).
        apply(8'h7F, 8'h01, 1'b0, "R3 pos ovf");
        apply(8'h80, 8'hFF, 1'b0, "R3 neg ovf");
        apply(8'h80, 8'h01, 1'b1, "R4 neg ovf");
        apply(8'h7F, 8'hFF, 1'b1, "R4 pos ovf");
        apply(8'h00, 8'h80, 1'b1, "R4 zero minus min");
        apply(8'h05, 8'h05, 1'b1, "R2 equal");
        apply(8'h00, 8'h01, 1'b1, "R2 borrow");
        // Mode toggling with fixed operands (R6): output follows mode at once.
        apply(8'h3C, 8'h5A, 1'b0, "R1 toggle add");
        apply(8'h3C, 8'h5A, 1'b1, "R2 toggle sub");
        // Exhaustive sweep in both modes (R1..R4, R7 via assertions).
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y++)
                    apply(x, y, m[0], m[0] ? "R2 sweep" : "R1 sweep");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule